// File: doc/BRIEF.md
# Mobile SDRAM Low-Power State Tracker

This block sits on the device side of a mobile SDRAM command bus and follows the low-power life of the memory. On every rising clock edge it samples the clock-enable and the four command strobes, along with an indication that every bank is idle. From these it decides whether the device is active, in self refresh or in deep power down.

While in self refresh it generates its own refresh strobes. Each strobe carries a bank and a row, and the strobes cover only the region chosen by the partial-array field. The spacing between strobes comes from the temperature field. The block also keeps one data-valid flag per bank. Writes set a flag. Deep power-down entry clears all flags, and leaving self refresh clears the flag of every bank that was not refreshed in full.

A controller model or a memory model uses the outputs to decide which stored contents it can still trust.

Top module: `lp_sdram_tracker`

## Requirements
- R1: After reset, `state` is 0, `data_valid` is all zero and `rfsh_stb` is low. The state codes are 0 for active, 1 for self refresh and 2 for deep power down.
- R2: In the active state, a refresh command (cs_n=0, ras_n=0, cas_n=0, we_n=1) sampled with cke low and `banks_idle` high moves the state to self refresh on the next cycle. At that edge, `par_sel` and `temp_sel` are captured for the whole stay.
- R3: In the active state, a power-down command (cs_n=0, ras_n=1, cas_n=1, we_n=0) sampled with cke low and `banks_idle` high moves the state to deep power down and clears every `data_valid` bit.
- R4: When `banks_idle` is low, a refresh command or a power-down command leaves the state active.
- R5: From self refresh or deep power down, cke sampled high returns the state to active at that edge. While cke stays low, deep power down is held with no strobes.
- R6: In self refresh, `rfsh_stb` pulses for one cycle every IVL cycles, and the first pulse comes IVL edges after the entry edge. IVL is IVL0..IVL3, selected by temp_sel 0..3, and a higher code gives a longer interval.
- R7: Strobes walk the rows of a bank in ascending order, then move to the next bank, and wrap inside the region. The par_sel codes are: 0 for banks 0-3, 1 for banks 0-1, 2 for bank 0.
- R8: par_sel 3 gives half of bank 0 (rows with top row bit 0). par_sel 4 gives a quarter of bank 0 (rows with the top two row bits 0).
- R9: par_sel codes 5, 6 and 7 behave like code 0.
- R10: On self-refresh exit, a bank keeps its `data_valid` bit only if the region covered the whole bank. So codes 0/5/6/7 keep all four banks, code 1 keeps banks 0-1, code 2 keeps bank 0, and codes 3 and 4 keep none.
- R11: In the active state with cke high, a write (cs_n=0, ras_n=1, cas_n=0, we_n=0) sets `data_valid[ba]` whatever the value of par_sel. A write seen outside the active state has no effect.
- R12: If cke returns high in the very cycle a refresh is due, no strobe is given and the state goes to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address of a write |
| banks_idle | input | 1 | High when every bank is precharged |
| par_sel | input | 3 | Partial-array region code |
| temp_sel | input | 2 | Temperature code choosing the refresh interval |
| state | output | 2 | Current low-power state |
| rfsh_stb | output | 1 | One-cycle self-refresh strobe |
| rfsh_bank | output | 2 | Bank of the strobe |
| rfsh_row | output | ROW_BITS | Row of the strobe |
| data_valid | output | 4 | Per-bank retained-data flags |

## Verification
Two things can land in the same cycle. One is the end of self refresh, when cke rises. The other is a refresh that has come due, because the interval counter has reached zero. The bench times the entry so that the count has run out, first checks that the strobe is high while cke is still low, and then raises cke in that same cycle. It expects the strobe to drop at once and the state to read active after the next edge. A second collision puts a write command on the exit cycle: the write must leave `data_valid` untouched, because the state is still self refresh when the write is sampled.

// File: rtl/lp_sdram_tracker.sv
module lp_sdram_tracker #(
  parameter int ROW_BITS = 13,
  parameter int IVL0 = 390,
  parameter int IVL1 = 780,
  parameter int IVL2 = 1560,
  parameter int IVL3 = 3120
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [1:0]          ba,
  input  logic                banks_idle,
  input  logic [2:0]          par_sel,
  input  logic [1:0]          temp_sel,
  output logic [1:0]          state,
  output logic                rfsh_stb,
  output logic [1:0]          rfsh_bank,
  output logic [ROW_BITS-1:0] rfsh_row,
  output logic [3:0]          data_valid
);

  localparam int IMAX = (IVL3 > IVL2 ? (IVL3 > IVL1 ? (IVL3 > IVL0 ? IVL3 : IVL0) : (IVL1 > IVL0 ? IVL1 : IVL0))
                                     : (IVL2 > IVL1 ? (IVL2 > IVL0 ? IVL2 : IVL0) : (IVL1 > IVL0 ? IVL1 : IVL0)));
  localparam int CW = $clog2(IMAX + 1);
  localparam logic [ROW_BITS-1:0] ROW_ALL  = '1;
  localparam logic [ROW_BITS-1:0] ROW_HALF = ROW_ALL >> 1;
  localparam logic [ROW_BITS-1:0] ROW_QTR  = ROW_ALL >> 2;

  localparam logic [1:0] ST_ACT = 2'd0;
  localparam logic [1:0] ST_SR  = 2'd1;
  localparam logic [1:0] ST_DPD = 2'd2;

  logic [1:0]    st;
  logic [2:0]    reg_q;
  logic [CW-1:0] cnt, reload_q;
  logic [1:0]    bank_last;
  logic [ROW_BITS-1:0] row_last;
  logic [3:0]    keep;

  wire cmd_ref = !cs_n && !ras_n && !cas_n &&  we_n;
  wire cmd_dpd = !cs_n &&  ras_n &&  cas_n && !we_n;
  wire cmd_wr  = !cs_n &&  ras_n && !cas_n && !we_n;
  wire [2:0] region = (par_sel > 3'd4) ? 3'd0 : par_sel;
  wire due = (st == ST_SR) && (cnt == '0);

  function automatic logic [CW-1:0] ivl_of(input logic [1:0] t);
    case (t)
      2'd0:    return CW'(IVL0);
      2'd1:    return CW'(IVL1);
      2'd2:    return CW'(IVL2);
      default: return CW'(IVL3);
    endcase
  endfunction

  always_comb begin
    case (reg_q)
      3'd0:    begin bank_last = 2'd3; row_last = ROW_ALL;  keep = 4'b1111; end
      3'd1:    begin bank_last = 2'd1; row_last = ROW_ALL;  keep = 4'b0011; end
      3'd2:    begin bank_last = 2'd0; row_last = ROW_ALL;  keep = 4'b0001; end
      3'd3:    begin bank_last = 2'd0; row_last = ROW_HALF; keep = 4'b0000; end
      default: begin bank_last = 2'd0; row_last = ROW_QTR;  keep = 4'b0000; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_ACT;
      reg_q      <= 3'd0;
      cnt        <= '0;
      reload_q   <= '0;
      rfsh_bank  <= 2'd0;
      rfsh_row   <= '0;
      data_valid <= 4'b0000;
    end else begin
      case (st)
        ST_ACT: begin
          if (cke && cmd_wr)
            data_valid[ba] <= 1'b1;
          else if (!cke && banks_idle && cmd_ref) begin
            st        <= ST_SR;
            reg_q     <= region;
            cnt       <= ivl_of(temp_sel);
            reload_q  <= ivl_of(temp_sel) - CW'(1);
            rfsh_bank <= 2'd0;
            rfsh_row  <= '0;
          end else if (!cke && banks_idle && cmd_dpd) begin
            st         <= ST_DPD;
            data_valid <= 4'b0000;
          end
        end
        ST_SR: begin
          if (cke) begin
            st         <= ST_ACT;
            data_valid <= data_valid & keep;
          end else if (due) begin
            cnt <= reload_q;
            if (rfsh_row == row_last) begin
              rfsh_row  <= '0;
              rfsh_bank <= (rfsh_bank == bank_last) ? 2'd0 : rfsh_bank + 2'd1;
            end else
              rfsh_row <= rfsh_row + 1'b1;
          end else
            cnt <= cnt - CW'(1);
        end
        default: if (cke) st <= ST_ACT;
      endcase
    end
  end

  assign state    = st;
  assign rfsh_stb = due && !cke;

  a_r3_dpd_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_DPD) |-> data_valid == 4'b0000);

  a_r5_dpd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DPD && !cke) |=> st == ST_DPD);

  a_r4_busy_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACT && !banks_idle) |=> st == ST_ACT);

  a_r7_two_bank_region: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && reg_q == 3'd1) |-> !rfsh_bank[1]);

  a_r8_half_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && reg_q == 3'd3) |-> (rfsh_bank == 2'd0 && !rfsh_row[ROW_BITS-1]));

  a_r8_quarter_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && reg_q == 3'd4) |-> (rfsh_bank == 2'd0 && rfsh_row[ROW_BITS-1:ROW_BITS-2] == 2'b00));

  a_r11_no_set_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_ACT) |=> (data_valid & ~$past(data_valid)) == 4'b0000);

endmodule

// File: tb/lp_sdram_tracker_bench.sv
module lp_sdram_tracker_bench;
  localparam int RB = 3;
  logic clk = 0, rst_n = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, banks_idle = 1;
  logic [1:0] ba = 0, temp_sel = 0;
  logic [2:0] par_sel = 0;
  logic [1:0] state;
  logic rfsh_stb;
  logic [1:0] rfsh_bank;
  logic [RB-1:0] rfsh_row;
  logic [3:0] data_valid;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  lp_sdram_tracker #(.ROW_BITS(RB), .IVL0(2), .IVL1(3), .IVL2(4), .IVL3(6)) u_lp_sdram_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .banks_idle(banks_idle), .par_sel(par_sel), .temp_sel(temp_sel), .state(state),
    .rfsh_stb(rfsh_stb), .rfsh_bank(rfsh_bank), .rfsh_row(rfsh_row), .data_valid(data_valid));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cmd(input logic c, input logic r, input logic a, input logic w);
    cs_n = c; ras_n = r; cas_n = a; we_n = w;
  endtask

  task automatic wr(input logic [1:0] b);
    cke = 1; ba = b; cmd(0, 1, 0, 0); tick(); cmd(1, 1, 1, 1);
  endtask

  task automatic wr_all();
    for (int b = 0; b < 4; b++) wr(2'(b));
  endtask

  task automatic enter_sr(input int par, input int temp);
    par_sel = 3'(par); temp_sel = 2'(temp); banks_idle = 1; cke = 0;
    cmd(0, 0, 0, 1); tick(); cmd(1, 1, 1, 1);
    chk(state == 2'd1, "R2 enter self refresh", state, 1);
  endtask

  task automatic t_reset();
    chk(state == 2'd0, "R1 reset state", state, 0);
    chk(data_valid == 4'd0, "R1 reset valid", data_valid, 0);
    chk(rfsh_stb == 1'b0, "R1 reset strobe", rfsh_stb, 0);
  endtask

  task automatic t_write();
    par_sel = 3'd2;
    wr_all();
    chk(data_valid == 4'hF, "R11 writes set all banks", data_valid, 15);
  endtask

  task automatic t_busy();
    banks_idle = 0; cke = 0;
    cmd(0, 0, 0, 1); tick();
    chk(state == 2'd0, "R4 refresh while busy", state, 0);
    cmd(0, 1, 1, 0); tick();
    chk(state == 2'd0, "R4 power-down while busy", state, 0);
    chk(data_valid == 4'hF, "R4 valid kept", data_valid, 15);
    cmd(1, 1, 1, 1); cke = 1; banks_idle = 1; tick();
  endtask

  task automatic run_sr(input int par, input int temp, input int nstb, input logic [3:0] dv_exp, input string tag);
    int ivl, blast, rlast, eb, er, k, last, got, p;
    ivl = (temp == 0) ? 2 : (temp == 1) ? 3 : (temp == 2) ? 4 : 6;
    p = (par > 4) ? 0 : par;
    blast = (p == 0) ? 3 : (p == 1) ? 1 : 0;
    rlast = (p == 3) ? 3 : (p == 4) ? 1 : 7;
    eb = 0; er = 0; k = 0; last = 0; got = 0;
    enter_sr(par, temp);
    par_sel = 3'd0; temp_sel = 2'd0;
    while (got < nstb && k < 1000) begin
      tick(); k++;
      if (rfsh_stb) begin
        chk(rfsh_bank == 2'(eb), {tag, " bank"}, rfsh_bank, eb);
        chk(rfsh_row == RB'(er), {tag, " row"}, rfsh_row, er);
        chk(k - last == ivl, "R6 strobe spacing", k - last, ivl);
        last = k; got++;
        if (er == rlast) begin er = 0; eb = (eb == blast) ? 0 : eb + 1; end
        else er++;
      end
    end
    chk(got == nstb, {tag, " strobe count"}, got, nstb);
    cke = 1; tick();
    chk(state == 2'd0, "R5 self refresh exit", state, 0);
    chk(data_valid == dv_exp, "R10 valid after exit", data_valid, dv_exp);
  endtask

  task automatic t_dpd();
    wr_all();
    cke = 0; cmd(0, 1, 1, 0); tick(); cmd(1, 1, 1, 1);
    chk(state == 2'd2, "R3 enter deep power down", state, 2);
    chk(data_valid == 4'd0, "R3 valid cleared", data_valid, 0);
    for (int i = 0; i < 10; i++) begin
      tick();
      chk(state == 2'd2 && !rfsh_stb, "R5 deep power down held", state, 2);
    end
    cke = 1; tick();
    chk(state == 2'd0, "R5 deep power down exit", state, 0);
  endtask

  task automatic t_write_on_exit();
    enter_sr(0, 0);
    tick();
    cke = 1; ba = 2'd2; cmd(0, 1, 0, 0); tick(); cmd(1, 1, 1, 1);
    chk(state == 2'd0, "R5 exit with write", state, 0);
    chk(data_valid == 4'd0, "R11 write ignored outside active", data_valid, 0);
    wr(2'd2);
    chk(data_valid == 4'b0100, "R11 write after exit", data_valid, 4);
  endtask

  task automatic t_collide();
    enter_sr(0, 3);
    for (int i = 0; i < 6; i++) tick();
    chk(rfsh_stb == 1'b1, "R6 first strobe after IVL", rfsh_stb, 1);
    cke = 1; #1;
    chk(rfsh_stb == 1'b0, "R12 no strobe on exit cycle", rfsh_stb, 0);
    tick();
    chk(state == 2'd0, "R12 state active", state, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_write();
    t_busy();
    run_sr(0, 0, 33, 4'hF, "R7 all banks");
    run_sr(6, 1, 9, 4'hF, "R9 unsupported code");
    run_sr(1, 3, 17, 4'b0011, "R7 two banks");
    wr_all();
    run_sr(2, 2, 10, 4'b0001, "R7 one bank");
    wr_all();
    run_sr(3, 2, 6, 4'b0000, "R8 half bank");
    wr_all();
    run_sr(4, 1, 5, 4'b0000, "R8 quarter bank");
    t_dpd();
    t_write_on_exit();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule